// File: doc/BRIEF.md
# DMA Stream Interrupt Flag Bank

This block holds the interrupt state for an eight-stream DMA controller. Each stream delivers single-cycle event pulses for five conditions: transfer complete, half transfer, transfer error, direct-mode error and FIFO error. The bank latches every pulse into a sticky flag. Software reads the flags through two packed status words. The low word holds streams 0 to 3 and the high word holds streams 4 to 7. Software acknowledges flags by writing ones to a matching pair of clear registers.

The bank also keeps a small configuration word for each stream: a stream enable and three interrupt enables. Hardware drops a stream's enable as soon as that stream reports a transfer error or a direct-mode error. Each stream drives its own interrupt line. The line is the OR of that stream's latched flags, each masked by its enable. The enables for half transfer and FIFO error come in on separate input pins. All register access goes through a word-wide port with single-cycle writes and a combinational read.

Top module: `dma_irq_flag_bank`

## Requirements
- R1: After reset, every flag and every configuration bit is 0. As a result `irq` and `stream_en` are 0, and every register reads 0.
- R2: A pulse on an event input sets the matching flag at the next clock edge. Stream s reports in status word s/4 (low word at byte 0x0, high word at byte 0x4). Its 6-bit group starts at bit ((s&2)<<3)|((s&1)*6), which is bit 0, 6, 16 or 22. Inside a group, bit 5 is transfer complete, bit 4 half transfer, bit 3 transfer error, bit 2 direct-mode error and bit 0 FIFO error.
- R3: Writing to the clear register at 0x8 (low) or 0xC (high) clears each flag whose bit position holds a 1. Flags whose bit holds a 0 keep their value.
- R4: When an event pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R5: Bit 1 of every group reads 0, and so do bits 12 to 15 and 28 to 31 of both status words. A write to a status word address changes no flag.
- R6: The configuration word of stream s is at byte 0x10+4*s. Bit 0 is the stream enable, bit 1 the direct-mode-error interrupt enable, bit 2 the transfer-error interrupt enable and bit 4 the transfer-complete interrupt enable. All other bits read 0. Bit 0 also appears on `stream_en[s]`.
- R7: A transfer-error or direct-mode-error pulse clears the stream enable at the next edge, even when a configuration write sets it in the same cycle. A FIFO-error pulse leaves the enable unchanged.
- R8: `irq[s]` is the OR of the five flags of stream s, each ANDed with its enable. Half transfer uses `ht_ie[s]` and FIFO error uses `fe_ie[s]`.
- R9: A transfer-complete flag is latched and clearable while its interrupt enable is 0. In that case it does not raise `irq`.
- R10: The clear registers read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ev_tc | input | NUM_STREAMS | Transfer-complete event pulses |
| ev_ht | input | NUM_STREAMS | Half-transfer event pulses |
| ev_te | input | NUM_STREAMS | Transfer-error event pulses |
| ev_dme | input | NUM_STREAMS | Direct-mode-error event pulses |
| ev_fe | input | NUM_STREAMS | FIFO-error event pulses |
| ht_ie | input | NUM_STREAMS | Half-transfer interrupt enables |
| fe_ie | input | NUM_STREAMS | FIFO-error interrupt enables |
| stream_en | output | NUM_STREAMS | Stream enable bits |
| irq | output | NUM_STREAMS | Per-stream interrupt lines |

## Verification
The assertions check four properties on every cycle. An event always leaves its flag set on the next edge, even when a clear arrives at the same time. Flags stay stable when there is no event and no write. An error pulse always removes the stream enable, and the enable can only rise through a write. An interrupt line stays low whenever the stream has no flags. Only the bench scenarios can show the bit-level layout: the irregular group offsets, the split between low and high words, the selective clear and the configuration field positions. These scenarios also cover the masking of interrupts by each enable.

// File: rtl/dma_irq_flag_bank.sv
module dma_irq_flag_bank #(
  parameter int NUM_STREAMS = 8,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] CFG_BASE = 6'h10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [NUM_STREAMS-1:0] ev_tc,
  input  logic [NUM_STREAMS-1:0] ev_ht,
  input  logic [NUM_STREAMS-1:0] ev_te,
  input  logic [NUM_STREAMS-1:0] ev_dme,
  input  logic [NUM_STREAMS-1:0] ev_fe,
  input  logic [NUM_STREAMS-1:0] ht_ie,
  input  logic [NUM_STREAMS-1:0] fe_ie,
  output logic [NUM_STREAMS-1:0] stream_en,
  output logic [NUM_STREAMS-1:0] irq
);

  localparam int NS = NUM_STREAMS;
  localparam int NW = NS / 4;

  function automatic int grp_off(int s);
    return ((s & 2) << 3) | ((s & 1) * 6);
  endfunction

  logic [NS-1:0] tc_q, ht_q, te_q, dm_q, fe_q;
  logic [NS-1:0] en_q, dmie_q, teie_q, tcie_q;
  logic [NS-1:0] clr_tc, clr_ht, clr_te, clr_dm, clr_fe, cfg_wr;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      logic hit;
      hit       = reg_wr && (reg_addr == ADDR_W'(4 * (NW + s / 4)));
      clr_fe[s] = hit && reg_wdata[grp_off(s)];
      clr_dm[s] = hit && reg_wdata[grp_off(s) + 2];
      clr_te[s] = hit && reg_wdata[grp_off(s) + 3];
      clr_ht[s] = hit && reg_wdata[grp_off(s) + 4];
      clr_tc[s] = hit && reg_wdata[grp_off(s) + 5];
      cfg_wr[s] = reg_wr && (reg_addr == CFG_BASE + ADDR_W'(4 * s));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_q <= '0; ht_q <= '0; te_q <= '0; dm_q <= '0; fe_q <= '0;
      en_q <= '0; dmie_q <= '0; teie_q <= '0; tcie_q <= '0;
    end else begin
      tc_q   <= ev_tc  | (tc_q & ~clr_tc);
      ht_q   <= ev_ht  | (ht_q & ~clr_ht);
      te_q   <= ev_te  | (te_q & ~clr_te);
      dm_q   <= ev_dme | (dm_q & ~clr_dm);
      fe_q   <= ev_fe  | (fe_q & ~clr_fe);
      en_q   <= ((en_q & ~cfg_wr) | (cfg_wr & {NS{reg_wdata[0]}})) & ~(ev_te | ev_dme);
      dmie_q <= (dmie_q & ~cfg_wr) | (cfg_wr & {NS{reg_wdata[1]}});
      teie_q <= (teie_q & ~cfg_wr) | (cfg_wr & {NS{reg_wdata[2]}});
      tcie_q <= (tcie_q & ~cfg_wr) | (cfg_wr & {NS{reg_wdata[4]}});
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int s = 0; s < NS; s++) begin
      if (reg_addr == ADDR_W'(4 * (s / 4)))
        reg_rdata[grp_off(s) +: 6] = {tc_q[s], ht_q[s], te_q[s], dm_q[s], 1'b0, fe_q[s]};
      if (reg_addr == CFG_BASE + ADDR_W'(4 * s))
        reg_rdata[4:0] = {tcie_q[s], 1'b0, teie_q[s], dmie_q[s], en_q[s]};
    end
  end

  assign stream_en = en_q;
  assign irq = (tc_q & tcie_q) | (ht_q & ht_ie) | (te_q & teie_q) |
               (dm_q & dmie_q) | (fe_q & fe_ie);

endmodule

// File: rtl/flag_bank_chk.sv
module flag_bank_chk #(
  parameter int NS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [NS-1:0] ev_tc,
  input logic [NS-1:0] ev_ht,
  input logic [NS-1:0] ev_te,
  input logic [NS-1:0] ev_dme,
  input logic [NS-1:0] ev_fe,
  input logic [NS-1:0] tc_q,
  input logic [NS-1:0] ht_q,
  input logic [NS-1:0] te_q,
  input logic [NS-1:0] dm_q,
  input logic [NS-1:0] fe_q,
  input logic [NS-1:0] stream_en,
  input logic [NS-1:0] irq
);

  // R4
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tc | ev_ht | ev_te | ev_dme | ev_fe) != '0 |=>
      ((tc_q & $past(ev_tc)) == $past(ev_tc)) && ((ht_q & $past(ev_ht)) == $past(ev_ht)) &&
      ((te_q & $past(ev_te)) == $past(ev_te)) && ((dm_q & $past(ev_dme)) == $past(ev_dme)) &&
      ((fe_q & $past(ev_fe)) == $past(ev_fe)));

  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && (ev_tc | ev_ht | ev_te | ev_dme | ev_fe) == '0) |=>
      $stable({tc_q, ht_q, te_q, dm_q, fe_q}));

  // R7
  error_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_te | ev_dme) != '0 |=> (stream_en & $past(ev_te | ev_dme)) == '0);

  // R6
  en_rises_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (stream_en & ~$past(stream_en)) == '0);

  // R8
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_q | ht_q | te_q | dm_q | fe_q) == '0 |-> irq == '0);

endmodule

bind dma_irq_flag_bank flag_bank_chk #(.NS(NUM_STREAMS)) u_flag_bank_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
  .ev_tc(ev_tc), .ev_ht(ev_ht), .ev_te(ev_te), .ev_dme(ev_dme), .ev_fe(ev_fe),
  .tc_q(tc_q), .ht_q(ht_q), .te_q(te_q), .dm_q(dm_q), .fe_q(fe_q),
  .stream_en(stream_en), .irq(irq)
);

// File: tb/test_dma_irq_flag_bank.sv
`timescale 1ns/1ps
module test_dma_irq_flag_bank;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0]  ev_tc = '0, ev_ht = '0, ev_te = '0, ev_dme = '0, ev_fe = '0;
  logic [7:0]  ht_ie = '0, fe_ie = '0, stream_en, irq;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  dma_irq_flag_bank i_dma_irq_flag_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_tc(ev_tc), .ev_ht(ev_ht), .ev_te(ev_te), .ev_dme(ev_dme), .ev_fe(ev_fe),
    .ht_ie(ht_ie), .fe_ie(fe_ie), .stream_en(stream_en), .irq(irq));

  // {stream[2:0], group bit[2:0], expected status word}
  localparam logic [37:0] VEC [10] = '{
    {3'd0, 3'd5, 32'h0000_0020}, {3'd1, 3'd0, 32'h0000_0040},
    {3'd2, 3'd4, 32'h0010_0000}, {3'd3, 3'd3, 32'h0200_0000},
    {3'd4, 3'd2, 32'h0000_0004}, {3'd5, 3'd5, 32'h0000_0800},
    {3'd6, 3'd0, 32'h0001_0000}, {3'd7, 3'd5, 32'h0800_0000},
    {3'd7, 3'd0, 32'h0040_0000}, {3'd3, 3'd4, 32'h0400_0000}};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic set_ev(int s, int k);
    case (k)
      0: ev_fe[s] = 1; 2: ev_dme[s] = 1; 3: ev_te[s] = 1;
      4: ev_ht[s] = 1; default: ev_tc[s] = 1;
    endcase
  endtask

  task automatic pulse(int s, int k);
    @(negedge clk); set_ev(s, k);
    @(negedge clk); ev_tc = '0; ev_ht = '0; ev_te = '0; ev_dme = '0; ev_fe = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 and R10: reset state
    chk("R1 irq", {24'd0, irq}, 32'd0);
    chk("R1 stream_en", {24'd0, stream_en}, 32'd0);
    for (int a = 0; a < 48; a += 4) begin
      rd(6'(a), d); chk("R1 R10 read after reset", d, 32'd0);
    end

    // R2 R3: table of single-flag layouts
    for (int i = 0; i < 10; i++) begin
      int s, k, w;
      s = int'(VEC[i][37:35]); k = int'(VEC[i][34:32]); w = s / 4;
      pulse(s, k);
      rd(6'(4 * w), d); chk("R2 layout", d, VEC[i][31:0]);
      rd(6'(4 * (1 - w)), d); chk("R2 other word", d, 32'd0);
      wr(6'(8 + 4 * w), VEC[i][31:0]);
      rd(6'(4 * w), d); chk("R3 cleared", d, 32'd0);
    end

    // R5: all events on all streams, unused bits stay 0
    @(negedge clk); ev_tc = '1; ev_ht = '1; ev_te = '1; ev_dme = '1; ev_fe = '1;
    @(negedge clk); ev_tc = '0; ev_ht = '0; ev_te = '0; ev_dme = '0; ev_fe = '0;
    rd(6'h0, d); chk("R5 low full", d, 32'h0F7D_0F7D);
    rd(6'h4, d); chk("R5 high full", d, 32'h0F7D_0F7D);
    wr(6'h0, 32'h0);
    wr(6'h4, 32'hFFFF_FFFF);
    rd(6'h4, d); chk("R5 status write ignored", d, 32'h0F7D_0F7D);
    wr(6'hC, 32'h0);
    rd(6'h4, d); chk("R3 zero clear keeps", d, 32'h0F7D_0F7D);
    rd(6'hC, d); chk("R10 clear reads 0", d, 32'd0);
    wr(6'hC, 32'h0000_0800);
    rd(6'h4, d); chk("R3 selective clear", d, 32'h0F7D_077D);
    wr(6'h8, 32'hFFFF_FFFF);
    rd(6'h0, d); chk("R3 low all clear", d, 32'd0);
    rd(6'h4, d); chk("R3 high untouched", d, 32'h0F7D_077D);
    wr(6'hC, 32'hFFFF_FFFF);

    // R4: set wins over clear
    @(negedge clk); ev_tc[0] = 1; reg_wr = 1; reg_addr = 6'h8; reg_wdata = 32'h20;
    @(negedge clk); ev_tc = '0; reg_wr = 0; reg_wdata = '0;
    rd(6'h0, d); chk("R4 set wins", d, 32'h20);
    wr(6'h8, 32'h20);

    // R6: config fields
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h18, d); chk("R6 cfg readback", d, 32'h17);
    chk("R6 stream_en", {24'd0, stream_en}, 32'h04);

    // R7: errors drop the enable, FIFO error does not
    wr(6'h14, 32'h07);
    pulse(1, 3);
    chk("R7 te drops enable", {31'd0, stream_en[1]}, 32'd0);
    rd(6'h14, d); chk("R7 cfg after te", d, 32'h06);
    wr(6'h20, 32'h01);
    pulse(4, 0);
    chk("R7 fe keeps enable", {31'd0, stream_en[4]}, 32'd1);
    @(negedge clk); ev_dme[4] = 1; reg_wr = 1; reg_addr = 6'h20; reg_wdata = 32'h01;
    @(negedge clk); ev_dme = '0; reg_wr = 0; reg_wdata = '0;
    chk("R7 dme beats write", {31'd0, stream_en[4]}, 32'd0);

    // R8: interrupt masking
    wr(6'h1C, 32'h10);
    pulse(3, 5);
    chk("R8 tc irq", {31'd0, irq[3]}, 32'd1);
    wr(6'h8, 32'h0800_0000);
    chk("R8 irq after clear", {31'd0, irq[3]}, 32'd0);
    ht_ie[6] = 1;
    pulse(6, 4);
    chk("R8 ht irq", {31'd0, irq[6]}, 32'd1);
    ht_ie[6] = 0; #1;
    chk("R8 ht masked", {31'd0, irq[6]}, 32'd0);
    wr(6'hC, 32'h0010_0000);

    // R9: tc latched with its enable off
    pulse(0, 5);
    chk("R9 no irq", {31'd0, irq[0]}, 32'd0);
    rd(6'h0, d); chk("R9 flag latched", d & 32'h3F, 32'h20);
    wr(6'h8, 32'h20);
    rd(6'h0, d); chk("R9 flag cleared", d & 32'h3F, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule